// File: doc/BRIEF.md
# Receive Frame Queue Pointer Manager

This block owns the address pointers of a word-organised receive queue whose depth is a power of two of 32-bit words. A frame is written into the queue speculatively, word by word, while it is still arriving. It becomes visible to the reader only when the receiver commits it. An aborted frame, or one that ran out of space, is discarded by moving the speculative pointer back to the last commit, so a reader never sees part of a frame. A separate back-fill pointer can be parked on words that were reserved earlier in the frame, such as timestamp slots, and stepped through them later without reserving more space.

The surrounding logic drives single-cycle strobes and uses the pointers as memory addresses. The memory array, frame counting and overrun detection live outside this block. The block reports how many words the reader sees as free. That count moves only on commits and reads, never on speculative writes.

Top module: `rxq_ptr_mgr`

## Requirements
- R1: While `rst_n` is low, and after it is released, with no strobes applied, every pointer reads 0, `rd_ptr_nxt_o` reads 1 and `free_words_o` equals DEPTH.
- R2: Each `raw_wr_i` strobe that is not overridden advances `raw_ptr_o` by one, modulo DEPTH.
- R3: A `commit_i` strobe loads `wr_ptr_o` with the value `raw_ptr_o` held before that edge. A raw write in the same cycle still advances the raw pointer.
- R4: An `abort_i` or `ovr_abort_i` strobe sets `raw_ptr_o` to the committed pointer. This overrides a raw write in the same cycle and cancels a commit in the same cycle, so `wr_ptr_o` is unchanged.
- R5: `ts_cap_i` loads `ts_ptr_o` from the pre-edge raw pointer. `ts_inc_i` advances it by one modulo DEPTH, and the capture wins when both are strobed together. Neither strobe changes `free_words_o`.
- R6: Each `rd_inc_i` strobe advances `rd_ptr_o` by one modulo DEPTH. `rd_ptr_nxt_o` always equals `rd_ptr_o` plus one modulo DEPTH, in the same cycle.
- R7: An effective commit lowers `free_words_o` by (raw minus committed) modulo DEPTH, taken before the edge. A read raises it by one, and both updates apply when they coincide. Raw writes, reverts and back-fill strobes leave it unchanged, and it never exceeds DEPTH.
- R8: A `release_i` strobe clears all pointers and sets `free_words_o` to DEPTH at the next edge, overriding every other strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| release_i | input | 1 | Synchronous queue release, clears all state |
| raw_wr_i | input | 1 | One speculative word written |
| commit_i | input | 1 | Current frame accepted |
| abort_i | input | 1 | Current frame abandoned |
| ovr_abort_i | input | 1 | Current frame dropped for lack of space |
| ts_cap_i | input | 1 | Park back-fill pointer on the raw pointer |
| ts_inc_i | input | 1 | Step back-fill pointer |
| rd_inc_i | input | 1 | Reader consumed one word |
| rd_ptr_o | output | PTR_W | Read pointer |
| rd_ptr_nxt_o | output | PTR_W | Read pointer plus one |
| wr_ptr_o | output | PTR_W | Committed write pointer |
| raw_ptr_o | output | PTR_W | Speculative write pointer |
| ts_ptr_o | output | PTR_W | Back-fill pointer |
| free_words_o | output | PTR_W+1 | Words free as seen by the reader |

## Verification
Every registered result appears at the first rising edge after its strobe. Only `rd_ptr_nxt_o` follows the read pointer within the same cycle. Leaving reset takes two further edges because the reset is synchronised. The bench drives strobes just after a falling edge and lets the behavioural model advance on the rising edge. It compares all outputs at the following falling edge, so each comparison lands exactly one register stage after its cause. The directed cases cover coinciding strobes: commit with a raw write, revert with a commit, commit with a read, capture with a step, and release with everything. These are followed by constrained random traffic that wraps the pointers many times.

// File: rtl/rxq_ptr_pkg.sv
package rxq_ptr_pkg;

  // Commands steering the two write pointers in one cycle.
  typedef struct packed {
    logic clr;
    logic revert;
    logic commit;
    logic raw_wr;
  } wr_cmd_t;

  // Action taken by the back-fill pointer in one cycle.
  typedef enum logic [1:0] {
    TS_HOLD  = 2'd0,
    TS_LOAD  = 2'd1,
    TS_STEP  = 2'd2,
    TS_CLEAR = 2'd3
  } ts_act_e;

  // Clear beats capture, and capture beats step.
  function automatic ts_act_e ts_decode(input logic clr, input logic cap,
                                        input logic inc);
    ts_act_e act;
    if (clr)      act = TS_CLEAR;
    else if (cap) act = TS_LOAD;
    else if (inc) act = TS_STEP;
    else          act = TS_HOLD;
    return act;
  endfunction

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/rxq_wr_ptrs.sv
module rxq_wr_ptrs
  import rxq_ptr_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  wr_cmd_t          cmd,
  output logic [PTR_W-1:0] raw_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] commit_len,
  output logic             commit_ok
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] raw_q, raw_d, wr_q, wr_d;
  logic             raw_en, wr_en;

  always_comb begin
    commit_ok  = cmd.commit & ~cmd.revert & ~cmd.clr;
    commit_len = raw_q - wr_q;
    raw_en     = cmd.clr | cmd.revert | cmd.raw_wr;
    wr_en      = cmd.clr | commit_ok;
    if (cmd.clr)         raw_d = '0;
    else if (cmd.revert) raw_d = wr_q;
    else                 raw_d = raw_q + ONE;
    if (cmd.clr)         wr_d = '0;
    else                 wr_d = raw_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_q <= '0;
    end else if (wr_en) begin
      wr_q <= wr_d;
    end
  end

  assign raw_ptr = raw_q;
  assign wr_ptr  = wr_q;
endmodule

// File: rtl/rxq_ts_ptr.sv
module rxq_ts_ptr
  import rxq_ptr_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             clr,
  input  logic             cap,
  input  logic             inc,
  input  logic [PTR_W-1:0] raw_ptr,
  output logic [PTR_W-1:0] ts_ptr
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  ts_act_e          act;
  logic [PTR_W-1:0] ts_q, ts_d;
  logic             ts_en;

  always_comb begin
    act   = ts_decode(clr, cap, inc);
    ts_en = (act != TS_HOLD);
    unique case (act)
      TS_CLEAR: ts_d = '0;
      TS_LOAD:  ts_d = raw_ptr;
      TS_STEP:  ts_d = ts_q + ONE;
      default:  ts_d = ts_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ts_q <= '0;
    end else if (ts_en) begin
      ts_q <= ts_d;
    end
  end

  assign ts_ptr = ts_q;
endmodule

// File: rtl/rxq_rd_side.sv
module rxq_rd_side #(
  parameter int DEPTH  = 64,
  parameter int PTR_W  = 6,
  parameter int FREE_W = 7
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              clr,
  input  logic              rd_inc,
  input  logic              commit_ok,
  input  logic [PTR_W-1:0]  commit_len,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  rd_ptr_nxt,
  output logic [FREE_W-1:0] free_words
);
  localparam logic [PTR_W-1:0]  ONE    = PTR_W'(1);
  localparam logic [FREE_W-1:0] FULL_F = FREE_W'(DEPTH);

  logic [PTR_W-1:0]  rd_q, rd_d;
  logic [FREE_W-1:0] free_q, free_d, sub_w, add_w;
  logic              rd_en, free_en;

  always_comb begin
    rd_en  = clr | rd_inc;
    rd_d   = clr ? '0 : rd_q + ONE;
    sub_w  = commit_ok ? {1'b0, commit_len} : '0;
    add_w  = {{(FREE_W-1){1'b0}}, rd_inc};
    free_en = clr | commit_ok | rd_inc;
    free_d  = clr ? FULL_F : (free_q - sub_w + add_w);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      free_q <= FULL_F;
    end else if (free_en) begin
      free_q <= free_d;
    end
  end

  assign rd_ptr     = rd_q;
  assign rd_ptr_nxt = rd_q + ONE;
  assign free_words = free_q;
endmodule

// File: rtl/rxq_ptr_mgr.sv
module rxq_ptr_mgr
  import rxq_ptr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int FREE_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              release_i,
  input  logic              raw_wr_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              ovr_abort_i,
  input  logic              ts_cap_i,
  input  logic              ts_inc_i,
  input  logic              rd_inc_i,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic [PTR_W-1:0]  rd_ptr_nxt_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [PTR_W-1:0]  raw_ptr_o,
  output logic [PTR_W-1:0]  ts_ptr_o,
  output logic [FREE_W-1:0] free_words_o
);
  logic             rst_q_n;
  wr_cmd_t          wcmd;
  logic [PTR_W-1:0] commit_len;
  logic             commit_ok;
  logic             rd_step;

  rxq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    wcmd.clr    = release_i;
    wcmd.revert = abort_i | ovr_abort_i;
    wcmd.commit = commit_i;
    wcmd.raw_wr = raw_wr_i;
    rd_step     = rd_inc_i & ~release_i;
  end

  rxq_wr_ptrs #(.PTR_W(PTR_W)) u_wr (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .cmd        (wcmd),
    .raw_ptr    (raw_ptr_o),
    .wr_ptr     (wr_ptr_o),
    .commit_len (commit_len),
    .commit_ok  (commit_ok)
  );

  rxq_ts_ptr #(.PTR_W(PTR_W)) u_ts (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .clr     (release_i),
    .cap     (ts_cap_i),
    .inc     (ts_inc_i),
    .raw_ptr (raw_ptr_o),
    .ts_ptr  (ts_ptr_o)
  );

  rxq_rd_side #(.DEPTH(DEPTH), .PTR_W(PTR_W), .FREE_W(FREE_W)) u_rd (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .clr        (release_i),
    .rd_inc     (rd_step),
    .commit_ok  (commit_ok),
    .commit_len (commit_len),
    .rd_ptr     (rd_ptr_o),
    .rd_ptr_nxt (rd_ptr_nxt_o),
    .free_words (free_words_o)
  );
endmodule

// File: rtl/rxq_ptr_mgr_chk.sv
module rxq_ptr_mgr_chk #(
  parameter int DEPTH  = 64,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int FREE_W = PTR_W + 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              release_i,
  input logic              raw_wr_i,
  input logic              commit_i,
  input logic              abort_i,
  input logic              ovr_abort_i,
  input logic              ts_cap_i,
  input logic              ts_inc_i,
  input logic              rd_inc_i,
  input logic [PTR_W-1:0]  rd_ptr_o,
  input logic [PTR_W-1:0]  wr_ptr_o,
  input logic [PTR_W-1:0]  raw_ptr_o,
  input logic [PTR_W-1:0]  ts_ptr_o,
  input logic [FREE_W-1:0] free_words_o
);
  logic revert;
  assign revert = abort_i | ovr_abort_i;

  a_r2_raw_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (raw_wr_i && !revert && !release_i) |=>
      raw_ptr_o == PTR_W'($past(raw_ptr_o) + 1'b1));

  a_r3_commit_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    (commit_i && !revert && !release_i) |=> wr_ptr_o == $past(raw_ptr_o));

  a_r4_revert: assert property (@(posedge clk) disable iff (!rst_q_n)
    (revert && !release_i) |=> raw_ptr_o == $past(wr_ptr_o));

  a_r4_commit_cancelled: assert property (@(posedge clk) disable iff (!rst_q_n)
    (revert && !release_i) |=> $stable(wr_ptr_o));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ts_cap_i && !release_i) |=> ts_ptr_o == $past(raw_ptr_o));

  a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_inc_i && !release_i) |=> rd_ptr_o == PTR_W'($past(rd_ptr_o) + 1'b1));

  a_r7_free_still: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!release_i && !rd_inc_i && !(commit_i && !revert)) |=> $stable(free_words_o));

  a_r7_free_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    free_words_o <= FREE_W'(DEPTH));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_q_n)
    release_i |=> (rd_ptr_o == '0 && wr_ptr_o == '0 && raw_ptr_o == '0 &&
                   ts_ptr_o == '0 && free_words_o == FREE_W'(DEPTH)));
endmodule

bind rxq_ptr_mgr rxq_ptr_mgr_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .FREE_W(FREE_W)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .release_i    (release_i),
  .raw_wr_i     (raw_wr_i),
  .commit_i     (commit_i),
  .abort_i      (abort_i),
  .ovr_abort_i  (ovr_abort_i),
  .ts_cap_i     (ts_cap_i),
  .ts_inc_i     (ts_inc_i),
  .rd_inc_i     (rd_inc_i),
  .rd_ptr_o     (rd_ptr_o),
  .wr_ptr_o     (wr_ptr_o),
  .raw_ptr_o    (raw_ptr_o),
  .ts_ptr_o     (ts_ptr_o),
  .free_words_o (free_words_o)
);

// File: tb/rxq_ptr_mgr_bench.sv
module rxq_ptr_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 32;
  localparam int PW = $clog2(D);
  localparam int FW = PW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic release_i = 0, raw_wr_i = 0, commit_i = 0, abort_i = 0, ovr_abort_i = 0;
  logic ts_cap_i = 0, ts_inc_i = 0, rd_inc_i = 0;
  logic [PW-1:0] rd_ptr_o, rd_ptr_nxt_o, wr_ptr_o, raw_ptr_o, ts_ptr_o;
  logic [FW-1:0] free_words_o;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0;
  int m_rd = 0, m_wr = 0, m_raw = 0, m_ts = 0, m_free = D;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_ptr_mgr #(.DEPTH(D)) u_rxq_ptr_mgr (
    .clk(clk), .rst_n(rst_n), .release_i(release_i), .raw_wr_i(raw_wr_i),
    .commit_i(commit_i), .abort_i(abort_i), .ovr_abort_i(ovr_abort_i),
    .ts_cap_i(ts_cap_i), .ts_inc_i(ts_inc_i), .rd_inc_i(rd_inc_i),
    .rd_ptr_o(rd_ptr_o), .rd_ptr_nxt_o(rd_ptr_nxt_o), .wr_ptr_o(wr_ptr_o),
    .raw_ptr_o(raw_ptr_o), .ts_ptr_o(ts_ptr_o), .free_words_o(free_words_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: behaviour taken from the requirements.
  always @(posedge clk) begin
    int len;
    bit rev;
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_raw = 0; m_ts = 0; m_free = D;
    end else if (release_i) begin
      m_rd = 0; m_wr = 0; m_raw = 0; m_ts = 0; m_free = D;
    end else begin
      int o_raw;
      len   = (m_raw - m_wr + D) % D;
      rev   = abort_i | ovr_abort_i;
      o_raw = m_raw;
      if (rev) m_raw = m_wr;
      else if (raw_wr_i) m_raw = (m_raw + 1) % D;
      if (commit_i && !rev) begin m_wr = o_raw; m_free = m_free - len; end
      if (ts_cap_i) m_ts = o_raw;
      else if (ts_inc_i) m_ts = (m_ts + 1) % D;
      if (rd_inc_i) begin m_rd = (m_rd + 1) % D; m_free = m_free + 1; end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R6", "rd_ptr", int'(rd_ptr_o), m_rd);
      chk("R6", "rd_ptr_nxt", int'(rd_ptr_nxt_o), (m_rd + 1) % D);
      chk("R3", "wr_ptr", int'(wr_ptr_o), m_wr);
      chk("R2", "raw_ptr", int'(raw_ptr_o), m_raw);
      chk("R5", "ts_ptr", int'(ts_ptr_o), m_ts);
      chk("R7", "free_words", int'(free_words_o), m_free);
    end
  end

  task automatic cyc(input bit rw, cm, ab, ov, tc, ti, rd, rel);
    @(negedge clk); #1;
    raw_wr_i = rw; commit_i = cm; abort_i = ab; ovr_abort_i = ov;
    ts_cap_i = tc; ts_inc_i = ti; rd_inc_i = rd; release_i = rel;
    @(posedge clk); #1;
    raw_wr_i = 0; commit_i = 0; abort_i = 0; ovr_abort_i = 0;
    ts_cap_i = 0; ts_inc_i = 0; rd_inc_i = 0; release_i = 0;
  endtask

  task automatic writes(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic settle;
    @(negedge clk); #2;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    cmp_en = 1;
    settle();
    chk("R1", "free in reset", int'(free_words_o), D);
    chk("R1", "raw in reset", int'(raw_ptr_o), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    settle();
    chk("R1", "rd after reset", int'(rd_ptr_o), 0);
    chk("R1", "rd_nxt after reset", int'(rd_ptr_nxt_o), 1);
    chk("R1", "free after reset", int'(free_words_o), D);

    // Frame with two reserved slots, then back-fill.
    writes(3);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    writes(2);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    settle();
    chk("R3", "wr after commit", int'(wr_ptr_o), 5);
    chk("R7", "free after commit", int'(free_words_o), 27);
    chk("R5", "ts after two steps", int'(ts_ptr_o), 5);

    // Commit together with a raw write.
    writes(3);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R3", "wr with raw write", int'(wr_ptr_o), 8);
    chk("R3", "raw with commit", int'(raw_ptr_o), 9);
    chk("R7", "free", int'(free_words_o), 24);

    // Abort overrides a raw write.
    writes(2);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    settle();
    chk("R4", "raw after abort", int'(raw_ptr_o), 8);
    chk("R7", "free after abort", int'(free_words_o), 24);

    // Overrun revert cancels a coinciding commit.
    writes(2);
    cyc(0, 1, 0, 1, 0, 0, 0, 0);
    settle();
    chk("R4", "raw after overrun", int'(raw_ptr_o), 8);
    chk("R4", "wr unchanged", int'(wr_ptr_o), 8);

    // Commit and read in the same cycle.
    writes(4);
    cyc(0, 1, 0, 0, 0, 0, 1, 0);
    settle();
    chk("R7", "commit plus read", int'(free_words_o), 21);
    chk("R6", "rd after read", int'(rd_ptr_o), 1);

    // Capture wins over step.
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    settle();
    chk("R5", "capture over step", int'(ts_ptr_o), 12);

    // Wrap all pointers.
    reads(11);
    writes(30);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R2", "raw wrapped", int'(raw_ptr_o), 10);
    chk("R7", "free after long frame", int'(free_words_o), 2);
    reads(30);
    settle();
    chk("R6", "rd wrapped", int'(rd_ptr_o), 10);
    chk("R6", "rd_nxt wrapped", int'(rd_ptr_nxt_o), 11);

    // Release overrides everything.
    writes(3);
    cyc(1, 1, 0, 0, 1, 1, 1, 1);
    settle();
    chk("R8", "raw after release", int'(raw_ptr_o), 0);
    chk("R8", "ts after release", int'(ts_ptr_o), 0);
    chk("R8", "free after release", int'(free_words_o), D);

    // Constrained random traffic, compared every cycle by the model.
    void'($urandom(7));
    for (int i = 0; i < 4000; i++) begin
      int occ, rdable, r;
      bit rw, cm, ab, ov, tc, ti, rd, rel;
      occ    = (D - m_free) + ((m_raw - m_wr + D) % D);
      rdable = D - m_free;
      r  = int'($urandom_range(0, 999));
      rw = (occ < D - 2) && (r % 3 != 0);
      cm = (r % 11 == 0);
      ab = (r % 47 == 0);
      ov = (r % 53 == 0);
      tc = (r % 13 == 0);
      ti = (r % 5 == 0);
      rd = (rdable > 0) && (int'($urandom_range(0, 2)) != 0);
      rel = (r == 500);
      cyc(rw, cm, ab, ov, tc, ti, rd, rel);
    end
    settle();
    summary();
  end
endmodule